// File: doc/BRIEF.md
# Bidirectional Code-Stream Buffer

This block buffers a compressed code stream between a 32-bit memory-transfer side and an 8-bit stream side. One storage array of 160 words of 32 bits (640 bytes) serves both directions. The selected mode decides which way data flows. In the two read-out modes, decode and playback, the wide side writes whole words and the narrow side takes them out a byte at a time. Decode sends those bytes to a codec port and playback sends them to a separate peripheral port. In compress mode, a codec pushes bytes in, the block packs them into words, and the wide side drains those words.

In compress mode the stream is cut into fields. An end-of-field strobe closes the current field: any partly filled word is padded with zero bytes and stored, and a sticky done flag is raised until software acknowledges it. A byte-granular fill level, full and empty flags, and a transfer request driven by a programmable burst size tell the memory-transfer engine when a whole burst can move. The mode may only be changed while the buffer holds nothing. A change clears all pointers and any partial word.

Top module: `code_fifo_bidir`

## Requirements
- R1: After reset the mode is decode (code 0), `empty`=1, `full`=0, `level`=0 and `field_done`=0.
- R2: In decode (mode code 0), words written with `dma_wr_en` leave on `code_data` one byte per `code_valid`&&`code_ready` handshake, bits [7:0] first and bits [31:24] last. `guest_valid` stays 0.
- R3: In playback (mode code 1), the same byte order is delivered on `guest_data`/`guest_valid`/`guest_ready`, and `code_valid` stays 0.
- R4: In compress (mode code 2), each byte accepted on `cin_data` with `cin_valid`&&`cin_ready` is packed least significant byte first. A completed word is read on `dma_rd_data` and removed by `dma_rd_en`.
- R5: In compress mode, a `field_end` pulse stores any partial word padded with zero bytes in its upper positions and sets `field_done`. `field_done` holds until `field_ack`. `cin_ready` is 0 during the `field_end` cycle.
- R6: `level` equals the bytes held, from 0 to 640. `full` is 1 when all 160 words are occupied, counting a partly read word. `empty` is 1 when `level` is 0.
- R7: The narrow reader sees `*_valid`=0 when no data is held. `cin_ready` is 0 when all words are occupied. A `dma_wr_en` while full, or a byte offered while `cin_ready`=0, changes neither `level` nor the stream.
- R8: `mode_load` updates the mode from `mode_req` only when `level` is 0, and it flushes all pointers and the partial word. It is ignored when `level`≠0 or when `mode_req` is 3.
- R9: `dma_req` is 1 when, in decode or playback, free words ≥ `burst_words`, or, in compress, stored whole words ≥ `burst_words`. `burst_words` must lie in 1..160.
- R10: A `dma_rd_en` in decode or playback mode, and a `field_end` outside compress mode, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Requested mode: 0 decode, 1 playback, 2 compress |
| mode_load | input | 1 | Apply `mode_req` (taken only when empty) |
| mode_o | output | 2 | Current mode |
| burst_words | input | 8 | Burst size in words for `dma_req` |
| dma_wr_en | input | 1 | Write one word (decode/playback) |
| dma_wr_data | input | 32 | Word to write |
| dma_rd_en | input | 1 | Remove head word (compress) |
| dma_rd_data | output | 32 | Head word |
| dma_req | output | 1 | A burst can move now |
| code_data | output | 8 | Byte to codec port |
| code_valid | output | 1 | Codec port byte available |
| code_ready | input | 1 | Codec port takes byte |
| guest_data | output | 8 | Byte to peripheral port |
| guest_valid | output | 1 | Peripheral port byte available |
| guest_ready | input | 1 | Peripheral port takes byte |
| cin_data | input | 8 | Byte from codec (compress) |
| cin_valid | input | 1 | Codec offers a byte |
| cin_ready | output | 1 | Byte can be accepted |
| field_end | input | 1 | Close the current field (compress) |
| field_done | output | 1 | Sticky field-closed flag |
| field_ack | input | 1 | Clear `field_done` |
| full | output | 1 | All words occupied |
| empty | output | 1 | No bytes held |
| level | output | 10 | Bytes held |

## Verification
A wrong byte offset in the unpacker appears at once on the narrow port as a byte out of order inside a word. The scoreboard catches it at the first handshake after the fault. A lost packer byte count appears as a word with shifted or missing bytes at the next wide-side read, and `level` is off by the lost count from the next cycle. Pointer or count corruption shows in `level`, `full` and `dma_req` on the cycle after the write that caused it, and later as a stream that repeats or drops a word when the buffer is drained to empty.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

  typedef enum logic [1:0] {
    CF_DECODE = 2'd0,
    CF_PLAY   = 2'd1,
    CF_COMP   = 2'd2
  } cf_mode_e;

  // bytes held: whole words, minus bytes already taken from the head word,
  // plus bytes waiting in the packer
  function automatic int unsigned byte_fill(int unsigned words,
                                            int unsigned taken,
                                            int unsigned held);
    return words * 4 + held - taken;
  endfunction

  // one burst of 'burst' words can be moved in the current direction
  function automatic logic burst_due(logic          read_out_dir,
                                     int unsigned   words,
                                     int unsigned   depth,
                                     int unsigned   burst);
    if (read_out_dir) return (depth - words) >= burst;
    else              return words >= burst;
  endfunction

endpackage

// File: rtl/cfifo_mem.sv
module cfifo_mem #(
  parameter int DEPTH = 160,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [31:0]   push_data,
  input  logic          pop,
  output logic [31:0]   head_data,
  output logic [CW-1:0] words
);

  logic [31:0]   store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      words  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   words <= words + 1'b1;
        2'b01:   words <= words - 1'b1;
        default: words <= words;
      endcase
    end
  end

  assign head_data = store[rd_ptr];

  // R7: the storage never takes a word when every entry is occupied
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (words != CW'(DEPTH)));

  // R7: the storage never gives a word it does not hold
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (words != '0));

endmodule

// File: rtl/cfifo_unpack.sv
module cfifo_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [31:0] head_word,
  input  logic        take,
  output logic [7:0]  byte_out,
  output logic        pop_word,
  output logic [1:0]  ofs
);

  logic [31:0] shifted;

  always_comb begin
    shifted  = head_word >> {ofs, 3'b000};
    byte_out = shifted[7:0];
    pop_word = take && (ofs == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) ofs <= '0;
    else if (take)       ofs <= ofs + 1'b1;
  end

endmodule

// File: rtl/cfifo_pack.sv
module cfifo_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [7:0]  byte_in,
  input  logic        accept,
  input  logic        close,
  output logic        push_word,
  output logic [31:0] word_out,
  output logic [1:0]  cnt
);

  logic [23:0] acc;

  always_comb begin
    push_word = (accept && cnt == 2'd3) || (close && cnt != 2'd0);
    word_out  = close ? {8'h00, acc} : {byte_in, acc};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      acc <= '0;
      cnt <= '0;
    end else if (close || (accept && cnt == 2'd3)) begin
      acc <= '0;
      cnt <= '0;
    end else if (accept) begin
      case (cnt)
        2'd0:    acc[7:0]   <= byte_in;
        2'd1:    acc[15:8]  <= byte_in;
        default: acc[23:16] <= byte_in;
      endcase
      cnt <= cnt + 1'b1;
    end
  end

  // R4/R5: a field close and a byte never coincide
  a_r5_close_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
    close |-> !accept);

endmodule

// File: rtl/code_fifo_bidir.sv
module code_fifo_bidir
  import cfifo_pkg::*;
#(
  parameter int DEPTH = 160,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(DEPTH * 4 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_req,
  input  logic          mode_load,
  output logic [1:0]    mode_o,
  input  logic [CW-1:0] burst_words,
  input  logic          dma_wr_en,
  input  logic [31:0]   dma_wr_data,
  input  logic          dma_rd_en,
  output logic [31:0]   dma_rd_data,
  output logic          dma_req,
  output logic [7:0]    code_data,
  output logic          code_valid,
  input  logic          code_ready,
  output logic [7:0]    guest_data,
  output logic          guest_valid,
  input  logic          guest_ready,
  input  logic [7:0]    cin_data,
  input  logic          cin_valid,
  output logic          cin_ready,
  input  logic          field_end,
  output logic          field_done,
  input  logic          field_ack,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);

  cf_mode_e      mode_q;
  logic          comp_mode, read_out;
  logic          mode_switch;
  logic [CW-1:0] words;
  logic [31:0]   head;
  logic          mem_push, mem_pop;
  logic [31:0]   mem_wdata;
  logic          take, up_pop;
  logic [1:0]    up_ofs;
  logic [7:0]    up_byte;
  logic          pk_accept, pk_close, pk_push;
  logic [31:0]   pk_word;
  logic [1:0]    pk_cnt;
  logic          words_full, words_none;

  always_comb begin
    comp_mode   = (mode_q == CF_COMP);
    read_out    = !comp_mode;
    words_full  = (words == CW'(DEPTH));
    words_none  = (words == '0);
    level       = LW'(byte_fill(32'(words), 32'(up_ofs), 32'(pk_cnt)));
    mode_switch = mode_load && (level == '0) && (mode_req != 2'd3);

    code_valid  = (mode_q == CF_DECODE) && !words_none;
    guest_valid = (mode_q == CF_PLAY)   && !words_none;
    code_data   = up_byte;
    guest_data  = up_byte;
    take        = (code_valid && code_ready) || (guest_valid && guest_ready);

    cin_ready   = comp_mode && !words_full && !field_end && !mode_switch;
    pk_accept   = cin_valid && cin_ready;
    pk_close    = comp_mode && field_end && !mode_switch;

    mem_push    = read_out ? (dma_wr_en && !words_full) : pk_push;
    mem_wdata   = read_out ? dma_wr_data : pk_word;
    mem_pop     = read_out ? up_pop : (dma_rd_en && !words_none);

    dma_rd_data = head;
    dma_req     = burst_due(read_out, 32'(words), 32'(DEPTH), 32'(burst_words));
    full        = words_full;
    empty       = (level == '0);
    mode_o      = mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= CF_DECODE;
    else if (mode_switch) mode_q <= cf_mode_e'(mode_req);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         field_done <= 1'b0;
    else if (pk_close)  field_done <= 1'b1;
    else if (field_ack) field_done <= 1'b0;
  end

  cfifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .flush(mode_switch),
    .push(mem_push), .push_data(mem_wdata), .pop(mem_pop),
    .head_data(head), .words(words)
  );

  cfifo_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(mode_switch),
    .head_word(head), .take(take), .byte_out(up_byte),
    .pop_word(up_pop), .ofs(up_ofs)
  );

  cfifo_pack u_pack (
    .clk(clk), .rst_n(rst_n), .flush(mode_switch),
    .byte_in(cin_data), .accept(pk_accept), .close(pk_close),
    .push_word(pk_push), .word_out(pk_word), .cnt(pk_cnt)
  );

  // R6: never more bytes than the array holds
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH * 4));

  // R8: a load while data is held leaves the mode alone
  a_r8_busy_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && level != '0) |=> $stable(mode_o));

  // R8: without a load the mode never moves
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(mode_o));

  // R8: an accepted switch leaves the buffer empty
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch |=> (level == '0));

  // R5: the done flag only rises from a field end in compress mode
  a_r5_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_done) |-> $past(field_end && mode_o == 2'd2));

  // R7/R2/R3: no byte is offered while no word is stored
  a_r7_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    words_none |-> !(code_valid || guest_valid));

endmodule

// File: tb/tb_code_fifo_bidir.sv
`timescale 1ns/100ps
module tb_code_fifo_bidir;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_req = 2'd0;
  logic        mode_load = 1'b0;
  logic [1:0]  mode_o;
  logic [7:0]  burst_words = 8'd8;
  logic        dma_wr_en = 1'b0;
  logic [31:0] dma_wr_data = '0;
  logic        dma_rd_en = 1'b0;
  logic [31:0] dma_rd_data;
  logic        dma_req;
  logic [7:0]  code_data, guest_data, cin_data = '0;
  logic        code_valid, guest_valid, cin_ready;
  logic        code_ready = 1'b0, guest_ready = 1'b0, cin_valid = 1'b0;
  logic        field_end = 1'b0, field_ack = 1'b0, field_done;
  logic        full, empty;
  logic [9:0]  level;

  int nchk = 0, nfail = 0, rxcnt = 0;
  logic [7:0]  exp_b[$];
  logic [31:0] exp_w[$];
  logic [31:0] pend = '0;
  int          pend_n = 0;

  always #2.5 clk = ~clk;

  code_fifo_bidir dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // monitor: compares every transfer against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (code_valid && code_ready) begin
        chk(exp_b.size() != 0 && code_data == exp_b[0], "R2 code byte",
            code_data, exp_b.size() != 0 ? exp_b[0] : 0);
        if (exp_b.size() != 0) void'(exp_b.pop_front());
        rxcnt++;
      end
      if (guest_valid && guest_ready) begin
        chk(exp_b.size() != 0 && guest_data == exp_b[0], "R3 guest byte",
            guest_data, exp_b.size() != 0 ? exp_b[0] : 0);
        if (exp_b.size() != 0) void'(exp_b.pop_front());
        rxcnt++;
      end
      if (dma_rd_en && exp_w.size() != 0) begin
        chk(dma_rd_data == exp_w[0], "R4 packed word", dma_rd_data, exp_w[0]);
        void'(exp_w.pop_front());
      end
    end
  end

  task automatic dma_write(input logic [31:0] w, input bit expect_kept);
    dma_wr_en = 1'b1; dma_wr_data = w;
    if (expect_kept) for (int k = 0; k < 4; k++) exp_b.push_back(w[8*k +: 8]);
    step();
    dma_wr_en = 1'b0;
  endtask

  task automatic read_bytes(input int n, input bit guest);
    int target = rxcnt + n;
    int c = 0;
    while (rxcnt < target) begin
      if (guest) guest_ready = (c % 3) != 1; else code_ready = (c % 4) != 2;
      c++;
      step();
    end
    code_ready = 1'b0; guest_ready = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    bit ok;
    cin_valid = 1'b1; cin_data = b;
    do begin
      #0.5; ok = cin_ready;
      step();
    end while (!ok);
    cin_valid = 1'b0;
    pend = pend | (32'(b) << (8 * pend_n));
    pend_n++;
    if (pend_n == 4) begin exp_w.push_back(pend); pend = '0; pend_n = 0; end
  endtask

  task automatic end_field();
    field_end = 1'b1; step(); field_end = 1'b0;
    if (pend_n != 0) begin exp_w.push_back(pend); pend = '0; pend_n = 0; end
  endtask

  task automatic read_words(input int n);
    for (int k = 0; k < n; k++) begin dma_rd_en = 1'b1; step(); end
    dma_rd_en = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_req = m; mode_load = 1'b1; step(); mode_load = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return {8'(i), 8'(i + 1) ^ 8'h5a, ~8'(i), 8'(i * 3)};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(); step(); rst_n = 1'b1; step();
    // R1 reset state
    chk(mode_o == 2'd0, "R1 mode", mode_o, 0);
    chk(empty && !full, "R1 empty/full", {empty, full}, 2'b10);
    chk(level == 0, "R1 level", level, 0);
    chk(!field_done, "R1 field_done", field_done, 0);
    chk(dma_req, "R9 req at reset", dma_req, 1);

    // decode: three words, byte order LSB first
    for (int i = 0; i < 3; i++) dma_write(pat(i), 1);
    chk(level == 12, "R6 level 12", level, 12);
    dma_rd_en = 1'b1; step(); dma_rd_en = 1'b0;
    chk(level == 12, "R10 dma read ignored in decode", level, 12);
    chk(!guest_valid && code_valid, "R2 port select", {guest_valid, code_valid}, 2'b01);
    read_bytes(12, 0);
    chk(!code_valid && empty, "R7 reader stalls empty", {code_valid, empty}, 2'b01);
    chk(exp_b.size() == 0, "R2 stream drained", exp_b.size(), 0);

    // fill to full, request threshold
    for (int i = 0; i < 152; i++) dma_write(pat(i + 10), 1);
    chk(dma_req, "R9 free 8 of burst 8", dma_req, 1);
    dma_write(pat(200), 1);
    chk(!dma_req, "R9 free 7 below burst", dma_req, 0);
    for (int i = 0; i < 7; i++) dma_write(pat(i + 300), 1);
    chk(full && level == 640, "R6 full at 640", level, 640);
    dma_write(32'hDEADBEEF, 0);
    chk(level == 640, "R7 write when full ignored", level, 640);
    set_mode(2'd2);
    chk(mode_o == 2'd0, "R8 switch refused while busy", mode_o, 0);
    read_bytes(640, 0);
    chk(empty && exp_b.size() == 0, "R7 full drain matched", exp_b.size(), 0);

    // playback
    set_mode(2'd1);
    chk(mode_o == 2'd1, "R8 switch to playback", mode_o, 1);
    dma_write(32'h44332211, 1); dma_write(32'h88776655, 1);
    chk(!code_valid && guest_valid, "R3 port select", {code_valid, guest_valid}, 2'b01);
    read_bytes(8, 1);
    chk(empty && exp_b.size() == 0, "R3 stream drained", level, 0);

    // compress
    set_mode(2'd3);
    chk(mode_o == 2'd1, "R8 code 3 ignored", mode_o, 1);
    burst_words = 8'd2;
    set_mode(2'd2);
    chk(mode_o == 2'd2, "R8 switch to compress", mode_o, 2);
    chk(!dma_req, "R9 compress none stored", dma_req, 0);
    for (int i = 0; i < 9; i++) put_byte(8'(8'h10 + i));
    chk(level == 9, "R6 level 9 with partial", level, 9);
    chk(dma_req, "R9 compress two words", dma_req, 1);
    end_field();
    chk(level == 12 && field_done, "R5 pad and done", {level, field_done}, {10'd12, 1'b1});
    read_words(3);
    chk(field_done && empty, "R5 done held until ack", field_done, 1);
    field_ack = 1'b1; step(); field_ack = 1'b0;
    chk(!field_done, "R5 ack clears", field_done, 0);
    end_field();
    chk(field_done && level == 0, "R5 empty field end", {field_done, level}, {1'b1, 10'd0});
    field_ack = 1'b1; step(); field_ack = 1'b0;

    for (int i = 0; i < 640; i++) put_byte(8'(i * 7 + 1));
    chk(full && level == 640 && !cin_ready, "R7 writer stalls full", level, 640);
    cin_valid = 1'b1; cin_data = 8'hEE; step(); step(); cin_valid = 1'b0;
    chk(level == 640, "R7 byte refused when full", level, 640);
    read_words(160);
    chk(empty && exp_w.size() == 0, "R4 full drain matched", exp_w.size(), 0);

    // field end outside compress
    set_mode(2'd0);
    field_end = 1'b1; step(); field_end = 1'b0;
    chk(!field_done && level == 0, "R10 field end ignored in decode", field_done, 0);

    finish_run();
  end

endmodule